// File: doc/BRIEF.md
# Real-Mode Addressing-Byte Effective Offset Unit

This unit takes the addressing byte that follows an opcode in a 16-bit real-mode processor and produces the 16-bit effective offset of the memory operand. On a start strobe it captures the byte, the four address-capable registers (BX, BP, SI, DI), the code segment and the current instruction pointer. It then pulls zero, one or two displacement bytes from the instruction stream, one byte per accepted fetch. Each fetch goes to the physical address formed from the code segment and the instruction pointer, and the pointer steps by one after each byte.

When the last byte has arrived, the unit raises a single-cycle completion pulse. Alongside it, it presents the three fields of the byte, the offset, a flag that picks the stack segment as the default segment, the number of displacement bytes taken, the updated instruction pointer, and an indication that the operand is a register rather than memory. Segment overrides, operand access and execution belong to the surrounding pipeline.

Top module: `ea_calc`

## Requirements
- R1: The captured byte is reported as mode = bits 7:6, reg = bits 5:3, rm = bits 2:0.
- R2: For mode 0 with rm other than 6, the offset is the base for rm: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 7 BX. No displacement byte is fetched.
- R3: For mode 0 with rm 6, the offset equals a 16-bit direct value taken from two fetched bytes, low byte first, and the stack-default flag stays low.
- R4: For mode 1, one byte is fetched, sign-extended to 16 bits and added to the base, where rm 6 selects BP.
- R5: For mode 2, two bytes are fetched, low byte first, and the 16-bit value is added to the base, where rm 6 selects BP.
- R6: The stack-default flag is high exactly for rm 2 or 3 in modes 0 to 2, and for rm 6 in modes 1 and 2.
- R7: All offset sums wrap modulo 65536.
- R8: Each displacement fetch presents address (CS×16 + IP) mod 2^20. IP steps by one, modulo 65536, per accepted byte, and the final IP is reported.
- R9: For mode 3, no fetch occurs, the register-operand flag is high, the offset is 0, the stack-default flag is low, the displacement count is 0, and completion is raised in the cycle after the start.
- R10: Completion is a one-cycle pulse in the cycle after the final displacement byte is accepted. The displacement count then equals the number of bytes the mode requires.
- R11: A start strobe that arrives while fetching is in progress is ignored, and the operation in flight completes with its own results.
- R12: After reset, completion, fetch request and busy are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture byte, registers, CS and IP when idle |
| mrm_byte | input | 8 | Addressing byte |
| bx_in | input | 16 | BX value |
| bp_in | input | 16 | BP value |
| si_in | input | 16 | SI value |
| di_in | input | 16 | DI value |
| cs_in | input | 16 | Code segment |
| ip_in | input | 16 | IP of the first displacement byte |
| fetch_ack | input | 1 | Displacement byte on fetch_data is accepted this cycle |
| fetch_data | input | 8 | Displacement byte |
| fetch_req | output | 1 | A displacement byte is wanted |
| fetch_addr | output | 20 | Physical address of the wanted byte |
| busy | output | 1 | Displacement fetching in progress |
| valid | output | 1 | Completion pulse |
| mod_f | output | 2 | Mode field |
| reg_f | output | 3 | Reg field |
| rm_f | output | 3 | Rm field |
| ea_offset | output | 16 | Effective offset |
| ss_default | output | 1 | Stack segment is the default segment |
| disp_count | output | 2 | Displacement bytes taken |
| reg_operand | output | 1 | Operand is a register named by rm |
| ip_next | output | 16 | IP after the displacement bytes |

## Verification
The checks assume that the environment raises fetch_ack only while fetch_req is high. The stepping of IP and the capture of each displacement byte are tied to the request being present. The stimulus obeys this: ack is driven only after the request has been seen, with zero to two idle cycles inserted first. The checks also assume that reset is applied before the first start. The bench drives start only while the unit is idle, with one exception: a deliberate strobe during a fetch wait, used to show that such a strobe is dropped.

// File: rtl/ea_pkg.sv
package ea_pkg;

    parameter int OFS_W     = 16;
    parameter int BYTE_W    = 8;
    parameter int SEG_SHIFT = 4;
    parameter int PHYS_W    = 20;
    parameter int MAX_DISP  = 2;
    parameter int CNT_W     = $clog2(MAX_DISP + 1);

    localparam logic [1:0] MODE_NODISP = 2'd0;
    localparam logic [1:0] MODE_D8     = 2'd1;
    localparam logic [1:0] MODE_D16    = 2'd2;
    localparam logic [1:0] MODE_REG    = 2'd3;
    localparam logic [2:0] RM_BP_OR_DIRECT = 3'd6;

    typedef struct packed {
        logic [1:0] mode;
        logic [2:0] regf;
        logic [2:0] rmf;
    } mrm_t;

    typedef struct packed {
        logic [OFS_W-1:0] bx;
        logic [OFS_W-1:0] bp;
        logic [OFS_W-1:0] si;
        logic [OFS_W-1:0] di;
    } ea_regs_t;

    typedef enum logic [0:0] {
        FS_IDLE  = 1'b0,
        FS_FETCH = 1'b1
    } fetch_state_t;

    function automatic mrm_t split_mrm(input logic [BYTE_W-1:0] b);
        mrm_t f;
        f.mode = b[7:6];
        f.regf = b[5:3];
        f.rmf  = b[2:0];
        return f;
    endfunction

    function automatic logic is_direct(input mrm_t f);
        return (f.mode == MODE_NODISP) && (f.rmf == RM_BP_OR_DIRECT);
    endfunction

    function automatic logic [CNT_W-1:0] disp_len(input mrm_t f);
        logic [CNT_W-1:0] n;
        case (f.mode)
            MODE_D8:     n = CNT_W'(1);
            MODE_D16:    n = CNT_W'(2);
            MODE_NODISP: n = is_direct(f) ? CNT_W'(2) : CNT_W'(0);
            default:     n = CNT_W'(0);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/ea_field_decode.sv
module ea_field_decode
    import ea_pkg::*;
(
    input  logic [BYTE_W-1:0] mrm_byte,
    output mrm_t              fields,
    output logic              reg_op,
    output logic              direct
);

    always_comb begin
        fields = split_mrm(mrm_byte);
        reg_op = (fields.mode == MODE_REG);
        direct = is_direct(fields);
    end

endmodule

// File: rtl/ea_base_sel.sv
module ea_base_sel
    import ea_pkg::*;
(
    input  logic [1:0]       mode,
    input  logic [2:0]       rmf,
    input  ea_regs_t         regs,
    output logic [OFS_W-1:0] base,
    output logic             ss_dflt
);

    logic no_bp;
    logic bp_pair;

    always_comb begin
        no_bp   = (mode == MODE_NODISP);
        bp_pair = (rmf == 3'd2) || (rmf == 3'd3);
        case (rmf)
            3'd0:    base = regs.bx + regs.si;
            3'd1:    base = regs.bx + regs.di;
            3'd2:    base = regs.bp + regs.si;
            3'd3:    base = regs.bp + regs.di;
            3'd4:    base = regs.si;
            3'd5:    base = regs.di;
            3'd6:    base = no_bp ? '0 : regs.bp;
            default: base = regs.bx;
        endcase
        ss_dflt = (mode != MODE_REG) &&
                  (bp_pair || ((rmf == RM_BP_OR_DIRECT) && !no_bp));
    end

endmodule

// File: rtl/ea_disp_fetch.sv
module ea_disp_fetch
    import ea_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            go,
    input  logic [CNT_W-1:0]                need,
    input  logic [OFS_W-1:0]                cs_in,
    input  logic [OFS_W-1:0]                ip_in,
    input  logic                            fetch_ack,
    input  logic [BYTE_W-1:0]               fetch_data,
    output logic                            fetch_req,
    output logic [PHYS_W-1:0]               fetch_addr,
    output logic                            busy,
    output logic                            done,
    output logic [CNT_W-1:0]                taken,
    output logic [OFS_W-1:0]                ip_cur,
    output logic [MAX_DISP-1:0][BYTE_W-1:0] disp_bytes
);

    fetch_state_t     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] need_q;
    logic [OFS_W-1:0] cs_q;
    logic [OFS_W-1:0] ip_q;
    logic             take;
    logic             last;

    assign take = (state_q == FS_FETCH) && fetch_ack;
    assign last = (CNT_W'(cnt_q + 1'b1) == need_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
            need_q  <= '0;
            cs_q    <= '0;
            ip_q    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                cs_q   <= cs_in;
                ip_q   <= ip_in;
                need_q <= need;
                cnt_q  <= '0;
                if (need == '0) begin
                    done <= 1'b1;
                end else begin
                    state_q <= FS_FETCH;
                end
            end else if (take) begin
                ip_q  <= ip_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
                if (last) begin
                    state_q <= FS_IDLE;
                    done    <= 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < MAX_DISP; g++) begin : g_disp
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst || go) begin
                byte_q <= '0;
            end else if (take && (cnt_q == CNT_W'(g))) begin
                byte_q <= fetch_data;
            end
        end
        assign disp_bytes[g] = byte_q;
    end

    assign fetch_req  = (state_q == FS_FETCH);
    assign busy       = (state_q == FS_FETCH);
    assign fetch_addr = PHYS_W'({cs_q, {SEG_SHIFT{1'b0}}}) + PHYS_W'(ip_q);
    assign taken      = cnt_q;
    assign ip_cur     = ip_q;

endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [BYTE_W-1:0]         mrm_byte,
    input  logic [OFS_W-1:0]          bx_in,
    input  logic [OFS_W-1:0]          bp_in,
    input  logic [OFS_W-1:0]          si_in,
    input  logic [OFS_W-1:0]          di_in,
    input  logic [OFS_W-1:0]          cs_in,
    input  logic [OFS_W-1:0]          ip_in,
    input  logic                      fetch_ack,
    input  logic [BYTE_W-1:0]         fetch_data,
    output logic                      fetch_req,
    output logic [PHYS_W-1:0]         fetch_addr,
    output logic                      busy,
    output logic                      valid,
    output logic [1:0]                mod_f,
    output logic [2:0]                reg_f,
    output logic [2:0]                rm_f,
    output logic [OFS_W-1:0]          ea_offset,
    output logic                      ss_default,
    output logic [CNT_W-1:0]          disp_count,
    output logic                      reg_operand,
    output logic [OFS_W-1:0]          ip_next
);

    logic                            accept;
    logic [BYTE_W-1:0]               mrm_q;
    ea_regs_t                        regs_q;
    mrm_t                            fields;
    logic                            reg_op;
    logic                            direct;
    logic [OFS_W-1:0]                base;
    logic                            ss_dflt;
    logic [MAX_DISP-1:0][BYTE_W-1:0] disp_bytes;
    logic [OFS_W-1:0]                disp_ext;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mrm_q  <= '0;
            regs_q <= '0;
        end else if (accept) begin
            mrm_q     <= mrm_byte;
            regs_q.bx <= bx_in;
            regs_q.bp <= bp_in;
            regs_q.si <= si_in;
            regs_q.di <= di_in;
        end
    end

    ea_field_decode u_dec (
        .mrm_byte (mrm_q),
        .fields   (fields),
        .reg_op   (reg_op),
        .direct   (direct)
    );

    ea_base_sel u_base (
        .mode    (fields.mode),
        .rmf     (fields.rmf),
        .regs    (regs_q),
        .base    (base),
        .ss_dflt (ss_dflt)
    );

    ea_disp_fetch u_fetch (
        .clk        (clk),
        .rst        (rst),
        .go         (accept),
        .need       (disp_len(split_mrm(mrm_byte))),
        .cs_in      (cs_in),
        .ip_in      (ip_in),
        .fetch_ack  (fetch_ack),
        .fetch_data (fetch_data),
        .fetch_req  (fetch_req),
        .fetch_addr (fetch_addr),
        .busy       (busy),
        .done       (valid),
        .taken      (disp_count),
        .ip_cur     (ip_next),
        .disp_bytes (disp_bytes)
    );

    always_comb begin
        case (fields.mode)
            MODE_D8:     disp_ext = {{(OFS_W-BYTE_W){disp_bytes[0][BYTE_W-1]}}, disp_bytes[0]};
            MODE_D16:    disp_ext = {disp_bytes[1], disp_bytes[0]};
            MODE_NODISP: disp_ext = direct ? {disp_bytes[1], disp_bytes[0]} : '0;
            default:     disp_ext = '0;
        endcase
        ea_offset = reg_op ? '0 : (base + disp_ext);
    end

    assign mod_f       = fields.mode;
    assign reg_f       = fields.regf;
    assign rm_f        = fields.rmf;
    assign ss_default  = ss_dflt;
    assign reg_operand = reg_op;

endmodule

// File: rtl/ea_calc_chk.sv
module ea_calc_chk
    import ea_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             fetch_req,
    input logic             fetch_ack,
    input logic             busy,
    input logic             valid,
    input logic [1:0]       mod_f,
    input logic [2:0]       reg_f,
    input logic [2:0]       rm_f,
    input logic [OFS_W-1:0] ea_offset,
    input logic             ss_default,
    input logic [CNT_W-1:0] disp_count,
    input logic             reg_operand,
    input logic [OFS_W-1:0] ip_next
);

    // R8: instruction pointer advances by one per accepted byte
    a_r8_ip_step: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && fetch_ack) |=> (ip_next == $past(ip_next) + 16'd1));

    // R10: completion never overlaps an active fetch
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        valid |-> (!busy && !fetch_req));

    // R9: register operands fetch nothing and carry no memory offset
    a_r9_reg_form: assert property (@(posedge clk) disable iff (rst)
        (valid && reg_operand) |-> (disp_count == '0 && !ss_default && ea_offset == '0));

    // R3: direct form takes two bytes and keeps the data segment
    a_r3_direct_ds: assert property (@(posedge clk) disable iff (rst)
        (valid && mod_f == 2'd0 && rm_f == 3'd6) |-> (!ss_default && disp_count == CNT_W'(2)));

    // R4: short displacement form takes exactly one byte
    a_r4_one_byte: assert property (@(posedge clk) disable iff (rst)
        (valid && mod_f == 2'd1) |-> (disp_count == CNT_W'(1)));

    // R6: stack default only for a memory form that names BP
    a_r6_ss_bp_only: assert property (@(posedge clk) disable iff (rst)
        (valid && ss_default) |-> (!reg_operand &&
            (rm_f == 3'd2 || rm_f == 3'd3 || (rm_f == 3'd6 && mod_f != 2'd0))));

    // R11: the captured fields stay put while fetching
    a_r11_hold_fields: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable({mod_f, reg_f, rm_f}));

endmodule

bind ea_calc ea_calc_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .fetch_req   (fetch_req),
    .fetch_ack   (fetch_ack),
    .busy        (busy),
    .valid       (valid),
    .mod_f       (mod_f),
    .reg_f       (reg_f),
    .rm_f        (rm_f),
    .ea_offset   (ea_offset),
    .ss_default  (ss_default),
    .disp_count  (disp_count),
    .reg_operand (reg_operand),
    .ip_next     (ip_next)
);

// File: tb/ea_calc_bench.sv
module ea_calc_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  mrm_byte = '0;
    logic [15:0] bx_in = '0, bp_in = '0, si_in = '0, di_in = '0;
    logic [15:0] cs_in = '0, ip_in = '0;
    logic        fetch_ack = 1'b0;
    logic [7:0]  fetch_data = '0;
    logic        fetch_req, busy, valid, ss_default, reg_operand;
    logic [19:0] fetch_addr;
    logic [1:0]  mod_f, disp_count;
    logic [2:0]  reg_f, rm_f;
    logic [15:0] ea_offset, ip_next;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ea_calc u_ea_calc (
        .clk(clk), .rst(rst), .start(start), .mrm_byte(mrm_byte),
        .bx_in(bx_in), .bp_in(bp_in), .si_in(si_in), .di_in(di_in),
        .cs_in(cs_in), .ip_in(ip_in), .fetch_ack(fetch_ack), .fetch_data(fetch_data),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .busy(busy), .valid(valid),
        .mod_f(mod_f), .reg_f(reg_f), .rm_f(rm_f), .ea_offset(ea_offset),
        .ss_default(ss_default), .disp_count(disp_count), .reg_operand(reg_operand),
        .ip_next(ip_next)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            report();
        end
    end

    function automatic logic [7:0] mem_at(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h9};
    endfunction

    function automatic int needed(input int md, input int rm);
        if (md == 3) return 0;
        if (md == 1) return 1;
        if (md == 2) return 2;
        return (rm == 6) ? 2 : 0;
    endfunction

    function automatic logic [15:0] ref_base(input int md, input int rm,
        input logic [15:0] bx, input logic [15:0] bp, input logic [15:0] si, input logic [15:0] di);
        case (rm)
            0: return bx + si;
            1: return bx + di;
            2: return bp + si;
            3: return bp + di;
            4: return si;
            5: return di;
            6: return (md == 0) ? 16'h0 : bp;
            default: return bx;
        endcase
    endfunction

    // one full operation with the reference model run alongside
    task automatic run_op(input logic [7:0] b, input logic [15:0] bx, input logic [15:0] bp,
                          input logic [15:0] si, input logic [15:0] di,
                          input logic [15:0] cs, input logic [15:0] ip,
                          input int gap, input bit poke);
        int md, rg, rm, need;
        logic [7:0]  got [2];
        logic [15:0] disp, exp_ea, ipc;
        logic [19:0] exp_addr;
        bit exp_ss;
        md = int'(b[7:6]); rg = int'(b[5:3]); rm = int'(b[2:0]);
        need = needed(md, rm);
        got[0] = 8'h0; got[1] = 8'h0;
        @(negedge clk);
        start = 1'b1; mrm_byte = b;
        bx_in = bx; bp_in = bp; si_in = si; di_in = di; cs_in = cs; ip_in = ip;
        @(negedge clk);
        start = 1'b0;
        ipc = ip;
        for (int i = 0; i < need; i++) begin
            for (int w = 0; w < gap; w++) begin
                check(fetch_req === 1'b1, "R8 request held", fetch_req, 1);
                check(valid === 1'b0, "R10 early done", valid, 0);
                if (poke && i == 0 && w == 0) begin
                    start = 1'b1; mrm_byte = 8'hC1; bx_in = 16'h5555;
                end
                @(negedge clk);
                start = 1'b0;
            end
            exp_addr = {cs, 4'h0} + {4'h0, ipc};
            check(fetch_addr === exp_addr, "R8 fetch address", fetch_addr, exp_addr);
            got[i] = mem_at(exp_addr);
            fetch_ack = 1'b1; fetch_data = got[i];
            @(negedge clk);
            fetch_ack = 1'b0;
            ipc = ipc + 16'd1;
        end
        if (md == 1)                      disp = {{8{got[0][7]}}, got[0]};
        else if (md == 2 || need == 2)    disp = {got[1], got[0]};
        else                              disp = 16'h0;
        exp_ea = (md == 3) ? 16'h0 : ref_base(md, rm, bx, bp, si, di) + disp;
        exp_ss = (md != 3) && (rm == 2 || rm == 3 || (rm == 6 && md != 0));
        check(valid === 1'b1, (md == 3) ? "R9 done next cycle" : "R10 done after last byte", valid, 1);
        check(mod_f === b[7:6] && reg_f === b[5:3] && rm_f === b[2:0], "R1 fields",
              {mod_f, reg_f, rm_f}, b);
        if (md == 3)
            check(ea_offset === exp_ea && reg_operand === 1'b1 && fetch_req === 1'b0, "R9 register form",
                  ea_offset, exp_ea);
        else if (md == 0 && rm == 6)
            check(ea_offset === exp_ea, "R3 direct offset", ea_offset, exp_ea);
        else if (md == 0)
            check(ea_offset === exp_ea, "R2 base table", ea_offset, exp_ea);
        else if (md == 1)
            check(ea_offset === exp_ea, "R4 short displacement", ea_offset, exp_ea);
        else
            check(ea_offset === exp_ea, "R5 word displacement", ea_offset, exp_ea);
        check(ss_default === exp_ss, "R6 stack default", ss_default, exp_ss);
        check(int'(disp_count) == need, "R10 byte count", disp_count, need);
        check(ip_next === ipc, "R8 final ip", ip_next, ipc);
        check(reg_operand === (md == 3), "R9 register flag", reg_operand, md == 3);
        @(negedge clk);
        check(valid === 1'b0, "R10 single pulse", valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(valid === 1'b0 && fetch_req === 1'b0 && busy === 1'b0, "R12 reset state",
              {valid, fetch_req, busy}, 0);
        // every addressing byte, varied registers and ack gaps
        for (int b = 0; b < 256; b++) begin
            run_op(8'(b), 16'h1000 + 16'(b * 3), 16'h8000 ^ 16'(b * 257),
                   16'hFFF0 + 16'(b), 16'(b * 97), 16'h0100 + 16'(b),
                   16'h2000 + 16'(b * 5), b % 3, 1'b0);
        end
        // R7: base sum and displacement sum wrap at 16 bits
        run_op(8'h00, 16'hFFFF, 16'h0, 16'h0002, 16'h0, 16'h0, 16'h0, 0, 1'b0);
        run_op(8'h87, 16'hFFF0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 1'b0);
        run_op(8'h45, 16'h0, 16'h0, 16'h0, 16'h0003, 16'h0, 16'h00FE, 1, 1'b0);
        // R8: IP wraps, physical address truncates to 20 bits
        run_op(8'h06, 16'h0, 16'h0, 16'h0, 16'h0, 16'h1234, 16'hFFFF, 0, 1'b0);
        run_op(8'h80, 16'h1, 16'h0, 16'h2, 16'h0, 16'hFFFF, 16'h0010, 2, 1'b0);
        // R11: a start while fetching is dropped
        run_op(8'h86, 16'h0, 16'h4000, 16'h0, 16'h0, 16'h0700, 16'h0040, 2, 1'b1);
        run_op(8'h46, 16'h0, 16'h0010, 16'h0, 16'h0, 16'h0700, 16'h007F, 1, 1'b1);
        report();
    end

endmodule